// File: doc/BRIEF.md
# Warp Issue Scheduler with Block Barrier

This block chooses which resident warp issues an instruction in each clock cycle. A warp is a group of 32 threads that run one instruction together. The contexts of all warps live on the multiprocessor at all times, so moving from one warp to another costs no cycles. Each cycle the scheduler looks at a fixed pool of warp slots and picks one that is eligible. A warp is eligible when its slot is valid, it is not stalled on a long-latency wait, and it is not parked at a barrier. The choice goes round-robin from the warp issued most recently. The result is presented as a registered warp index with a valid strobe.

Barrier tracking is built in. Each warp slot carries a thread-block tag that is set at launch. When the instruction on the issue outputs is a barrier, the decoder raises `bar_arrive_i` during the cycle that instruction is shown. From then on, that warp is held back until every valid warp with the same tag has arrived. The last arrival releases the whole block at once. Warps with different tags never wait for one another, and nothing spans the whole grid.

Top module: `warp_issue_sched`

## Requirements
- R1: While `rst_ni` is low, `issue_valid_o` is 0. With every warp eligible, the first issue after reset is warp 0.
- R2: When `issue_valid_o` is 1, the warp `issue_warp_o` was valid, not stalled and not waiting at a barrier in the cycle before. At most one warp issues per cycle.
- R3: Among the eligible warps, the pick is the first one found searching upward, with wrap-around, from the index just after the most recently issued warp.
- R4: A warp whose `warp_stall_i` bit is 1 is not issued in the following cycle.
- R5: `issue_valid_o` is 0 in any cycle after one where no warp was eligible.
- R6: If `bar_arrive_i` is 1 while `issue_valid_o` is 1, the warp shown on `issue_warp_o` enters barrier wait and is not issued again until its block is released. The one exception is when that arrival completes its block.
- R7: A block is released when an arrival leaves every valid warp with the same tag either waiting or arriving. At that clock edge the wait flags of all those warps clear, so the last arriving warp is eligible at that same edge.
- R8: Barrier waits are scoped by tag. The tag of warp w is `warp_blk_i[w*BLK_W +: BLK_W]`, and an arrival only ever involves warps with an equal tag.
- R9: A warp whose `warp_valid_i` bit is 0 is never issued, and its barrier wait flag is cleared.
- R10: `bar_arrive_i` is ignored in any cycle where `issue_valid_o` is 0. No warp enters barrier wait because of it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| warp_valid_i | input | NUM_WARPS | Slot holds a live warp |
| warp_stall_i | input | NUM_WARPS | Warp waits on a long-latency result |
| warp_blk_i | input | NUM_WARPS*BLK_W | Thread-block tag per warp, warp w at bits w*BLK_W |
| bar_arrive_i | input | 1 | Instruction on the issue outputs is a barrier |
| issue_valid_o | output | 1 | A warp issues this cycle |
| issue_warp_o | output | $clog2(NUM_WARPS) | Index of the issuing warp |

## Verification
The bench uses the default build: eight warps and three-bit block tags. This size is enough for several blocks of uneven size to share the pool, including one-warp blocks that release the moment they arrive, and for the round-robin pointer to wrap many times. Tag layouts change between phases, and the bench combines random stall masks, live-slot masks and barrier arrivals, driving arrivals in reaction to what actually issues. This reaches releases made by the last arrival, arrivals that a pointer wrap interrupts, and warps that leave while parked at a barrier.

// File: rtl/wis_pkg.sv
package wis_pkg;
  function automatic int unsigned wrap_add(int unsigned base, int unsigned step, int unsigned n);
    int unsigned s;
    s = base + step;
    if (s >= n) s = s - n;
    return s;
  endfunction
endpackage

// File: rtl/wis_barrier.sv
module wis_barrier #(
  parameter int NUM_WARPS = 8,
  parameter int BLK_W     = 3,
  localparam int IDX_W    = $clog2(NUM_WARPS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_WARPS-1:0]       valid_i,
  input  logic [NUM_WARPS*BLK_W-1:0] blk_i,
  input  logic                       arrive_i,
  input  logic [IDX_W-1:0]           arrive_idx_i,
  output logic [NUM_WARPS-1:0]       wait_o,
  output logic [NUM_WARPS-1:0]       hold_o,
  output logic [NUM_WARPS-1:0]       rel_mask_o,
  output logic                       release_o
);
  logic [NUM_WARPS-1:0] wait_q, wait_d, arr_oh, same_blk, covered;
  logic [BLK_W-1:0]     arr_blk;
  logic                 done;

  assign arr_blk = blk_i[arrive_idx_i*BLK_W +: BLK_W];

  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_warp
    assign arr_oh[w]   = arrive_i && (arrive_idx_i == IDX_W'(w));
    assign same_blk[w] = valid_i[w] && (blk_i[w*BLK_W +: BLK_W] == arr_blk);
    assign covered[w]  = !same_blk[w] || wait_q[w] || arr_oh[w];
  end

  assign done       = arrive_i && (&covered);
  assign release_o  = done;
  assign rel_mask_o = done ? same_blk : '0;
  assign hold_o     = done ? '0 : arr_oh;

  always_comb begin
    wait_d = (wait_q | hold_o) & ~rel_mask_o & valid_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) wait_q <= '0;
    else         wait_q <= wait_d;
  end

  assign wait_o = wait_q;
endmodule

// File: rtl/wis_elig.sv
module wis_elig #(
  parameter int NUM_WARPS = 8
) (
  input  logic [NUM_WARPS-1:0] valid_i,
  input  logic [NUM_WARPS-1:0] stall_i,
  input  logic [NUM_WARPS-1:0] wait_i,
  input  logic [NUM_WARPS-1:0] hold_i,
  output logic [NUM_WARPS-1:0] elig_o
);
  for (genvar w = 0; w < NUM_WARPS; w++) begin : g_el
    assign elig_o[w] = valid_i[w] & ~stall_i[w] & ~wait_i[w] & ~hold_i[w];
  end
endmodule

// File: rtl/wis_rr_arb.sv
module wis_rr_arb
  import wis_pkg::*;
#(
  parameter int NUM_WARPS = 8,
  localparam int IDX_W    = $clog2(NUM_WARPS)
) (
  input  logic [NUM_WARPS-1:0] req_i,
  input  logic [IDX_W-1:0]     last_i,
  output logic                 gnt_valid_o,
  output logic [IDX_W-1:0]     gnt_idx_o
);
  always_comb begin
    int unsigned c;
    gnt_valid_o = 1'b0;
    gnt_idx_o   = last_i;
    for (int i = 1; i <= NUM_WARPS; i++) begin
      c = wrap_add(32'(last_i), 32'(i), 32'(NUM_WARPS));
      if (!gnt_valid_o && req_i[c]) begin
        gnt_valid_o = 1'b1;
        gnt_idx_o   = IDX_W'(c);
      end
    end
  end
endmodule

// File: rtl/warp_issue_sched.sv
module warp_issue_sched #(
  parameter int NUM_WARPS = 8,
  parameter int BLK_W     = 3,
  localparam int IDX_W    = $clog2(NUM_WARPS)
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_WARPS-1:0]       warp_valid_i,
  input  logic [NUM_WARPS-1:0]       warp_stall_i,
  input  logic [NUM_WARPS*BLK_W-1:0] warp_blk_i,
  input  logic                       bar_arrive_i,
  output logic                       issue_valid_o,
  output logic [IDX_W-1:0]           issue_warp_o
);
  logic [NUM_WARPS-1:0] wait_q, hold, rel_mask, elig;
  logic                 release_w, gnt_valid, arrive;
  logic [IDX_W-1:0]     gnt_idx;

  assign arrive = bar_arrive_i && issue_valid_o;

  wis_barrier #(.NUM_WARPS(NUM_WARPS), .BLK_W(BLK_W)) i_barrier (
    .clk_i, .rst_ni,
    .valid_i(warp_valid_i), .blk_i(warp_blk_i),
    .arrive_i(arrive), .arrive_idx_i(issue_warp_o),
    .wait_o(wait_q), .hold_o(hold), .rel_mask_o(rel_mask), .release_o(release_w)
  );

  wis_elig #(.NUM_WARPS(NUM_WARPS)) i_elig (
    .valid_i(warp_valid_i), .stall_i(warp_stall_i),
    .wait_i(wait_q), .hold_i(hold), .elig_o(elig)
  );

  wis_rr_arb #(.NUM_WARPS(NUM_WARPS)) i_arb (
    .req_i(elig), .last_i(issue_warp_o),
    .gnt_valid_o(gnt_valid), .gnt_idx_o(gnt_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      issue_valid_o <= 1'b0;
      issue_warp_o  <= IDX_W'(NUM_WARPS - 1);
    end else begin
      issue_valid_o <= gnt_valid;
      if (gnt_valid) issue_warp_o <= gnt_idx;
    end
  end
endmodule

// File: rtl/wis_checker.sv
module wis_checker #(
  parameter int NUM_WARPS = 8,
  localparam int IDX_W    = $clog2(NUM_WARPS)
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic [NUM_WARPS-1:0] warp_valid_i,
  input logic [NUM_WARPS-1:0] warp_stall_i,
  input logic                 bar_arrive_i,
  input logic                 issue_valid_o,
  input logic [IDX_W-1:0]     issue_warp_o,
  input logic [NUM_WARPS-1:0] wait_q,
  input logic [NUM_WARPS-1:0] rel_mask,
  input logic                 release_w
);
  always_comb begin
    if (!rst_ni) p_reset_idle_r1: assert (!issue_valid_o);
  end

  p_issue_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> ((($past(warp_valid_i & ~warp_stall_i)) >> issue_warp_o) & 1) != 0);

  p_issue_unparked_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    issue_valid_o |-> ((($past(wait_q)) >> issue_warp_o) & 1) == 0);

  p_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(warp_valid_i & ~warp_stall_i) == '0) |-> !issue_valid_o);

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_valid_o && bar_arrive_i && !release_w)
      |=> !(issue_valid_o && issue_warp_o == $past(issue_warp_o)));

  p_release_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    release_w |=> (wait_q & $past(rel_mask)) == '0);

  p_no_stray_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !issue_valid_o |=> (wait_q & ~$past(wait_q)) == '0);

  p_invalid_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (wait_q & ~$past(warp_valid_i)) == '0);
endmodule

bind warp_issue_sched wis_checker #(.NUM_WARPS(NUM_WARPS)) i_wis_checker (
  .clk_i(clk_i), .rst_ni(rst_ni),
  .warp_valid_i(warp_valid_i), .warp_stall_i(warp_stall_i),
  .bar_arrive_i(bar_arrive_i), .issue_valid_o(issue_valid_o),
  .issue_warp_o(issue_warp_o), .wait_q(wait_q), .rel_mask(rel_mask),
  .release_w(release_w)
);

// File: tb/test_warp_issue_sched.sv
module test_warp_issue_sched;
  localparam int N  = 8;
  localparam int BW = 3;
  localparam int IW = $clog2(N);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [N-1:0]  warp_valid_i = '0;
  logic [N-1:0]  warp_stall_i = '0;
  logic [N*BW-1:0] warp_blk_i = '0;
  logic          bar_arrive_i = 1'b0;
  logic          issue_valid_o;
  logic [IW-1:0] issue_warp_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string cur_req = "R1";
  bit    done = 0;

  // reference model state
  bit m_wait [N];
  bit m_valid = 0;
  int m_warp  = N - 1;

  always #10 clk_i = ~clk_i;

  warp_issue_sched #(.NUM_WARPS(N), .BLK_W(BW)) i_warp_issue_sched (.*);

  function automatic int tag(int w);
    return int'(warp_blk_i[w*BW +: BW]);
  endfunction

  always @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      foreach (m_wait[w]) m_wait[w] = 0;
      m_valid = 0;
      m_warp  = N - 1;
    end else begin
      bit arrive, rel, found;
      bit hold [N];
      bit nw [N];
      int pick;
      arrive = bar_arrive_i && m_valid;
      rel = 0;
      foreach (hold[w]) hold[w] = 0;
      foreach (nw[w]) nw[w] = m_wait[w];
      if (arrive) begin
        rel = 1;
        for (int w = 0; w < N; w++)
          if (warp_valid_i[w] && tag(w) == tag(m_warp) && !m_wait[w] && w != m_warp) rel = 0;
        if (rel) begin
          for (int w = 0; w < N; w++)
            if (warp_valid_i[w] && tag(w) == tag(m_warp)) nw[w] = 0;
        end else begin
          hold[m_warp] = 1;
          nw[m_warp] = 1;
        end
      end
      found = 0;
      pick = m_warp;
      for (int i = 1; i <= N; i++) begin
        int c;
        c = (m_warp + i) % N;
        if (!found && warp_valid_i[c] && !warp_stall_i[c] && !m_wait[c] && !hold[c]) begin
          found = 1;
          pick = c;
        end
      end
      for (int w = 0; w < N; w++) m_wait[w] = nw[w] && warp_valid_i[w];
      m_valid = found;
      if (found) m_warp = pick;
    end
  end

  task automatic check(string req, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at cycle %0d", req, what, act, exp, cycles);
    end
  endtask

  // compare on every clock, away from the edge
  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
    cycles++;
    check(cur_req, int'(issue_valid_o), int'(m_valid), "issue_valid");
    if (m_valid) check(cur_req, int'(issue_warp_o), m_warp, "issue_warp");
  endtask

  task automatic set_tags(int t0, int t1, int t2, int t3, int t4, int t5, int t6, int t7);
    int t [N];
    t = '{t0, t1, t2, t3, t4, t5, t6, t7};
    for (int w = 0; w < N; w++) warp_blk_i[w*BW +: BW] = BW'(t[w]);
  endtask

  task automatic run_random(int n, int stall_pct, int bar_pct, int inval_pct);
    for (int k = 0; k < n; k++) begin
      for (int w = 0; w < N; w++) begin
        warp_stall_i[w] = ($urandom_range(99) < stall_pct);
        if (inval_pct > 0) warp_valid_i[w] = ($urandom_range(99) >= inval_pct);
      end
      bar_arrive_i = issue_valid_o && ($urandom_range(99) < bar_pct);
      step();
    end
    bar_arrive_i = 0;
  endtask

  initial begin
    set_tags(0, 0, 0, 0, 1, 1, 1, 1);
    #35;
    check("R1", int'(issue_valid_o), 0, "valid in reset");
    @(negedge clk_i);
    rst_ni = 1'b1;
    warp_valid_i = '1;
    cur_req = "R1";
    step();
    check("R1", int'(issue_warp_o), 0, "first issued warp");

    cur_req = "R3";
    for (int k = 0; k < 20; k++) step();

    cur_req = "R4";
    warp_stall_i = 8'b0101_0101;
    for (int k = 0; k < 8; k++) begin
      step();
      check("R4", int'(issue_warp_o[0]), 1, "stalled even warp issued");
    end
    run_random(40, 40, 0, 0);

    cur_req = "R5";
    warp_stall_i = '1;
    step();
    step();
    check("R5", int'(issue_valid_o), 0, "idle when all stalled");

    cur_req = "R10";
    bar_arrive_i = 1;
    step();
    step();
    bar_arrive_i = 0;
    warp_stall_i = '0;
    for (int k = 0; k < 10; k++) step();

    // directed barrier: block 0 = warps 0..3
    cur_req = "R6";
    warp_stall_i = '0;
    while (!(issue_valid_o && issue_warp_o == 0)) step();
    bar_arrive_i = 1;
    step();
    bar_arrive_i = 0;
    for (int k = 0; k < 10; k++) begin
      step();
      check("R6", int'(issue_valid_o && issue_warp_o == 0), 0, "parked warp 0 issued");
    end

    cur_req = "R7";
    for (int a = 1; a <= 3; a++) begin
      while (!(issue_valid_o && issue_warp_o == IW'(a))) step();
      bar_arrive_i = 1;
      step();
      bar_arrive_i = 0;
    end
    // warp 3's arrival released block 0; warp 0 eligible again soon
    begin
      bit seen0 = 0;
      for (int k = 0; k < N + 1; k++) begin
        step();
        if (issue_valid_o && issue_warp_o == 0) seen0 = 1;
      end
      check("R7", int'(seen0), 1, "warp 0 reissued after release");
    end

    cur_req = "R8";
    set_tags(0, 1, 2, 3, 0, 1, 2, 3);
    run_random(300, 20, 40, 0);
    set_tags(5, 5, 5, 6, 6, 7, 2, 2);
    run_random(300, 30, 50, 0);

    cur_req = "R9";
    run_random(300, 20, 50, 15);
    warp_valid_i = '0;
    step();
    step();
    check("R9", int'(issue_valid_o), 0, "no valid warps");
    warp_valid_i = '1;

    cur_req = "R2";
    set_tags(1, 1, 1, 1, 1, 1, 1, 1);
    run_random(400, 25, 30, 5);
    warp_valid_i = '1;
    warp_stall_i = '0;
    run_random(100, 0, 0, 0);

    done = 1;
  end

  initial begin
    int wd;
    wd = 0;
    while (!done && wd < 100000) begin
      @(posedge clk_i);
      wd++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles", wd, 100000);
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule